// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Block

This block is the register file that sits between a host processor and a remote microcontroller so that the two can pass short messages. The host sends up to eight 32-bit words by writing an inbox. The remote sends words back through an outbox. Each slot in either direction has its own pending bit. When the remote has consumed an inbox word, it clears that bit. When the host has handled an outbox message, it clears the matching bit.

Two interrupt lines signal pending work, one toward each side. An inbox mask chooses which inbox slot writes can raise the remote's interrupt. The host uses it to send a multi-word message that interrupts the remote only once, on the write of its last word. The host considers the previous transmission finished once the whole inbox status reads back zero. The host-side interrupt stays high while any outbox bit is pending, so it also works as a lock on the shared message memory until the host releases it.

A bank of scratch words can be read and written freely from both ports and raises no interrupt. Message bodies in shared memory, bus bridging and the software protocol are outside this block.

Top module: `mbox_regs`

## Requirements
- R1: A synchronous active-high reset clears every inbox slot, outbox slot, status bit, mask bit and scratch word to zero, and drives both interrupt outputs low.
- R2: A host write to byte offset 0x00 + 4·n (n = 0..7) stores the word in inbox slot n and sets bit n of the inbox status. The remote reads the slot at the same offset, and both ports read the inbox status at 0xC0 as bits 7:0. Address bits 1:0 are ignored.
- R3: A remote write to 0x20 + 4·n stores the word in outbox slot n and sets bit n of the outbox status. The host reads the slot at the same offset, and both ports read the outbox status at 0xC4 as bits 7:0.
- R4: The mask is bits 7:0 at 0xD0. The host can read and write it, and the remote can read it. The remote interrupt goes high on the clock edge after any inbox status bit is set whose mask bit is zero, and goes low on the clock edge after no such bit remains.
- R5: With mask bits 0..N−2 set, an N-word message written to slots 0..N−1 in order leaves the remote interrupt low until the write of slot N−1.
- R6: The remote clears inbox status bits by writing ones to 0xC0; zero bits leave their status unchanged. Once every bit is cleared, the host reads 0 at 0xC0.
- R7: The host interrupt goes high on the edge after any outbox status bit is set. It stays high until the host clears every set bit by writing ones to 0xC4, and then goes low on the following edge.
- R8: When a slot write sets a status bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.
- R9: Offsets 0x40 through 0xAC hold 28 scratch words that both ports read and write, with no effect on any status or interrupt. When both ports write the same scratch word in one cycle, the host's data is kept.
- R10: Reads from offsets outside the map (0xB0–0xBC, 0xC8–0xCC, 0xD4 and above) return zero, and writes to them change nothing. Writes that fall on locations the writing port cannot change are also ignored: host writes to outbox slots or to 0xC0, and remote writes to inbox slots, 0xC4 or 0xD0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| r_we | input | 1 | Remote write strobe |
| r_addr | input | 8 | Remote byte offset |
| r_wdata | input | 32 | Remote write data |
| r_rdata | output | 32 | Remote read data for r_addr, combinational |
| h_irq | output | 1 | Registered interrupt toward the host |
| r_irq | output | 1 | Registered interrupt toward the remote |

## Verification
The bench builds the block with its default parameters: eight slots per direction, 32-bit words and an 8-bit offset. That brings every mapped offset, every status bit and both ends of the scratch range within reach. A behavioural model follows both ports on every clock. The stimulus covers message lengths of one, four and eight words under the matching masks, clears that collide with sets on both status registers, and scratch writes from both ports to the same word. It also writes to every kind of location a port may not change.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    parameter int SLOTS = 8;
    parameter int DW    = 32;
    parameter int AW    = 8;

    localparam int WI_W      = AW - 2;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int IN_WORD0  = 0;
    localparam int OUT_WORD0 = SLOTS;
    localparam int SCR_WORD0 = 16;
    localparam int SCR_WORDS = 28;
    localparam int SCR_W     = $clog2(SCR_WORDS);
    localparam int INST_WORD = 48;
    localparam int OUST_WORD = 49;
    localparam int MASK_WORD = 52;

    typedef enum logic [2:0] {
        K_NONE, K_INBOX, K_OUTBOX, K_SCRATCH, K_INSTAT, K_OUTSTAT, K_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e       kind;
        logic [WI_W-1:0] idx;
    } reg_hit_t;

    function automatic reg_hit_t decode(input logic [AW-1:0] a);
        reg_hit_t h;
        int w;
        w = int'(a[AW-1:2]);
        h.kind = K_NONE;
        h.idx  = '0;
        if (w >= IN_WORD0 && w < IN_WORD0 + SLOTS) begin
            h.kind = K_INBOX;   h.idx = WI_W'(w - IN_WORD0);
        end else if (w >= OUT_WORD0 && w < OUT_WORD0 + SLOTS) begin
            h.kind = K_OUTBOX;  h.idx = WI_W'(w - OUT_WORD0);
        end else if (w >= SCR_WORD0 && w < SCR_WORD0 + SCR_WORDS) begin
            h.kind = K_SCRATCH; h.idx = WI_W'(w - SCR_WORD0);
        end else if (w == INST_WORD) begin
            h.kind = K_INSTAT;
        end else if (w == OUST_WORD) begin
            h.kind = K_OUTSTAT;
        end else if (w == MASK_WORD) begin
            h.kind = K_MASK;
        end
        return h;
    endfunction
endpackage

// File: rtl/mbox_slot_bank.sv
module mbox_slot_bank
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              clr_en,
    input  logic [SLOTS-1:0]  clr_bits,
    output logic [DW-1:0]     slot_q [SLOTS],
    output logic [SLOTS-1:0]  status
);
    logic [SLOTS-1:0] set_vec;
    logic [SLOTS-1:0] clr_vec;

    assign set_vec = wr_en  ? (SLOTS'(1) << wr_idx) : '0;
    assign clr_vec = clr_en ? clr_bits : '0;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)             slot_q[i] <= '0;
            else if (set_vec[i]) slot_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_vec) | set_vec;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> status[$past(wr_idx)]);

    // R6
    clr_done_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !wr_en) |=> ((status & $past(clr_bits)) == '0));

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (status == '0));
endmodule

// File: rtl/mbox_scratch.sv
module mbox_scratch
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             h_we,
    input  logic [SCR_W-1:0] h_idx,
    input  logic [DW-1:0]    h_wd,
    input  logic             r_we,
    input  logic [SCR_W-1:0] r_idx,
    input  logic [DW-1:0]    r_wd,
    output logic [DW-1:0]    mem [SCR_WORDS]
);
    for (genvar i = 0; i < SCR_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                  mem[i] <= '0;
            else if (h_we && h_idx == SCR_W'(i))      mem[i] <= h_wd;
            else if (r_we && r_idx == SCR_W'(i))      mem[i] <= r_wd;
        end
    end

    // R9
    host_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (h_we && r_we && h_idx == r_idx) |=> (mem[$past(h_idx)] == $past(h_wd)));
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          h_irq,
    output logic          r_irq
);
    reg_hit_t         h_hit, r_hit;
    logic [DW-1:0]    in_q  [SLOTS];
    logic [DW-1:0]    out_q [SLOTS];
    logic [DW-1:0]    scr_q [SCR_WORDS];
    logic [SLOTS-1:0] in_st, out_st, in_mask;

    assign h_hit = decode(h_addr);
    assign r_hit = decode(r_addr);

    mbox_slot_bank u_inbox (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (h_we && h_hit.kind == K_INBOX),
        .wr_idx  (h_hit.idx[SLOT_W-1:0]),
        .wr_data (h_wdata),
        .clr_en  (r_we && r_hit.kind == K_INSTAT),
        .clr_bits(r_wdata[SLOTS-1:0]),
        .slot_q  (in_q),
        .status  (in_st)
    );

    mbox_slot_bank u_outbox (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (r_we && r_hit.kind == K_OUTBOX),
        .wr_idx  (r_hit.idx[SLOT_W-1:0]),
        .wr_data (r_wdata),
        .clr_en  (h_we && h_hit.kind == K_OUTSTAT),
        .clr_bits(h_wdata[SLOTS-1:0]),
        .slot_q  (out_q),
        .status  (out_st)
    );

    mbox_scratch u_scratch (
        .clk  (clk),
        .rst  (rst),
        .h_we (h_we && h_hit.kind == K_SCRATCH),
        .h_idx(h_hit.idx[SCR_W-1:0]),
        .h_wd (h_wdata),
        .r_we (r_we && r_hit.kind == K_SCRATCH),
        .r_idx(r_hit.idx[SCR_W-1:0]),
        .r_wd (r_wdata),
        .mem  (scr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                              in_mask <= '0;
        else if (h_we && h_hit.kind == K_MASK) in_mask <= h_wdata[SLOTS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_irq <= 1'b0;
            r_irq <= 1'b0;
        end else begin
            h_irq <= |out_st;
            r_irq <= |(in_st & ~in_mask);
        end
    end

    always_comb begin
        case (h_hit.kind)
            K_INBOX:   h_rdata = in_q[h_hit.idx[SLOT_W-1:0]];
            K_OUTBOX:  h_rdata = out_q[h_hit.idx[SLOT_W-1:0]];
            K_SCRATCH: h_rdata = scr_q[h_hit.idx[SCR_W-1:0]];
            K_INSTAT:  h_rdata = DW'(in_st);
            K_OUTSTAT: h_rdata = DW'(out_st);
            K_MASK:    h_rdata = DW'(in_mask);
            default:   h_rdata = '0;
        endcase
    end

    always_comb begin
        case (r_hit.kind)
            K_INBOX:   r_rdata = in_q[r_hit.idx[SLOT_W-1:0]];
            K_OUTBOX:  r_rdata = out_q[r_hit.idx[SLOT_W-1:0]];
            K_SCRATCH: r_rdata = scr_q[r_hit.idx[SCR_W-1:0]];
            K_INSTAT:  r_rdata = DW'(in_st);
            K_OUTSTAT: r_rdata = DW'(out_st);
            K_MASK:    r_rdata = DW'(in_mask);
            default:   r_rdata = '0;
        endcase
    end

    // R4
    r_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(in_st & ~in_mask)) |=> r_irq);

    // R4
    r_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(in_st & ~in_mask)) |=> !r_irq);

    // R7
    h_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|out_st) |=> h_irq);

    // R7
    h_irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_st == '0) |=> !h_irq);
endmodule

// File: tb/mbox_regs_test.sv
module mbox_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_we = 1'b0, r_we = 1'b0;
    logic [7:0]  h_addr = '0, r_addr = '0;
    logic [31:0] h_wdata = '0, r_wdata = '0;
    logic [31:0] h_rdata, r_rdata;
    logic        h_irq, r_irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_in [8];
    logic [31:0] m_out [8];
    logic [31:0] m_scr [28];
    logic [7:0]  m_ist, m_ost, m_msk;
    logic        m_hirq, m_rirq;

    always #4 clk = ~clk;

    mbox_regs uut (
        .clk(clk), .rst(rst),
        .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .h_irq(h_irq), .r_irq(r_irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [7:0] a);
        int w;
        w = int'(a[7:2]);
        if (w < 8)                return m_in[w];
        else if (w < 16)          return m_out[w-8];
        else if (w < 44)          return m_scr[w-16];
        else if (w == 48)         return {24'h0, m_ist};
        else if (w == 49)         return {24'h0, m_ost};
        else if (w == 52)         return {24'h0, m_msk};
        return 32'h0;
    endfunction

    task automatic mreset();
        for (int i = 0; i < 8; i++) begin m_in[i] = '0; m_out[i] = '0; end
        for (int i = 0; i < 28; i++) m_scr[i] = '0;
        m_ist = '0; m_ost = '0; m_msk = '0; m_hirq = 0; m_rirq = 0;
    endtask

    task automatic mupdate();
        int hw, rw;
        logic [7:0] iset, oset, iclr, oclr;
        hw = int'(h_addr[7:2]);
        rw = int'(r_addr[7:2]);
        iset = '0; oset = '0; iclr = '0; oclr = '0;
        m_rirq = |(m_ist & ~m_msk);
        m_hirq = |m_ost;
        if (h_we && hw < 8) begin m_in[hw] = h_wdata; iset[hw] = 1'b1; end
        if (r_we && rw >= 8 && rw < 16) begin m_out[rw-8] = r_wdata; oset[rw-8] = 1'b1; end
        if (r_we && rw == 48) iclr = r_wdata[7:0];
        if (h_we && hw == 49) oclr = h_wdata[7:0];
        if (h_we && hw == 52) m_msk = h_wdata[7:0];
        if (r_we && rw >= 16 && rw < 44) m_scr[rw-16] = r_wdata;
        if (h_we && hw >= 16 && hw < 44) m_scr[hw-16] = h_wdata;
        m_ist = (m_ist & ~iclr) | iset;
        m_ost = (m_ost & ~oclr) | oset;
    endtask

    task automatic step(input string tag,
                        input logic hwe, input logic [7:0] ha, input logic [31:0] hd,
                        input logic rwe, input logic [7:0] ra, input logic [31:0] rd);
        h_we = hwe; h_addr = ha; h_wdata = hd;
        r_we = rwe; r_addr = ra; r_wdata = rd;
        #1;
        chk(tag, "h_rdata", h_rdata, mrd(ha));
        chk(tag, "r_rdata", r_rdata, mrd(ra));
        @(posedge clk);
        mupdate();
        @(negedge clk);
        chk(tag, "h_irq", 32'(h_irq), 32'(m_hirq));
        chk(tag, "r_irq", 32'(r_irq), 32'(m_rirq));
    endtask

    task automatic hwr(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1'b1, a, d, 1'b0, 8'hC0, '0);
    endtask

    task automatic rwr(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1'b0, 8'hC4, '0, 1'b1, a, d);
    endtask

    task automatic rd2(input string tag, input logic [7:0] ha, input logic [7:0] ra);
        step(tag, 1'b0, ha, '0, 1'b0, ra, '0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        mreset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state on both ports and both interrupt lines
        chk("R1", "h_irq after reset", 32'(h_irq), 32'h0);
        chk("R1", "r_irq after reset", 32'(r_irq), 32'h0);
        for (int i = 0; i < 8; i++) rd2("R1", 8'(i*4), 8'(32 + i*4));
        rd2("R1", 8'hC0, 8'hC4);
        rd2("R1", 8'hD0, 8'h40);

        // R2: host fills the inbox, remote reads it, status accumulates
        for (int i = 0; i < 8; i++) hwr("R2", 8'(i*4), 32'hA5000000 + 32'(i * 32'h1111));
        for (int i = 0; i < 8; i++) rd2("R2", 8'hC0, 8'(i*4));
        rd2("R2", 8'hC0, 8'h1D);

        // R6: partial clears, zero bits keep their state, then full clear
        rwr("R6", 8'hC0, 32'h0000000F);
        rd2("R6", 8'hC0, 8'hC0);
        rwr("R6", 8'hC0, 32'h00000000);
        rwr("R6", 8'hC0, 32'hFFFFFFF0);
        rd2("R6", 8'hC0, 8'hC0);

        // R4: mask readable by remote, masked bit alone keeps irq low
        hwr("R4", 8'hD0, 32'h00000002);
        rd2("R4", 8'hD0, 8'hD0);
        hwr("R4", 8'h04, 32'h12345678);
        rd2("R4", 8'hC0, 8'hD0);
        hwr("R4", 8'h08, 32'h9ABCDEF0);
        rd2("R4", 8'hC0, 8'hC0);
        rwr("R4", 8'hC0, 32'h00000004);
        rwr("R4", 8'hC0, 32'h00000002);

        // R5: four-word message, mask low three bits
        hwr("R5", 8'hD0, 32'h00000007);
        for (int i = 0; i < 4; i++) hwr("R5", 8'(i*4), 32'hC0DE0000 + 32'(i));
        rd2("R5", 8'hC0, 8'h0C);
        rwr("R5", 8'hC0, 32'h0000000F);
        // R5: single-word message, no mask
        hwr("R5", 8'hD0, 32'h00000000);
        hwr("R5", 8'h00, 32'h0000BEEF);
        rwr("R5", 8'hC0, 32'h00000001);
        // R5: eight-word message, mask low seven bits
        hwr("R5", 8'hD0, 32'h0000007F);
        for (int i = 0; i < 8; i++) hwr("R5", 8'(i*4), 32'h80000000 | 32'(i));
        rwr("R5", 8'hC0, 32'h000000FF);
        rd2("R5", 8'hC0, 8'hC0);

        // R3: remote writes outbox slots, host reads them
        rwr("R3", 8'h28, 32'h0BADF00D);
        rwr("R3", 8'h34, 32'h5A5A5A5A);
        rd2("R3", 8'h28, 8'h34);
        rd2("R3", 8'h34, 8'hC4);
        rd2("R3", 8'hC4, 8'h3C);

        // R7: interrupt held until every pending bit is cleared
        hwr("R7", 8'hC4, 32'h00000004);
        rd2("R7", 8'hC4, 8'hC4);
        hwr("R7", 8'hC4, 32'h00000020);
        rd2("R7", 8'hC4, 8'hC4);

        // R8: set and clear of one bit in the same cycle, both directions
        hwr("R8", 8'hD0, 32'h00000000);
        hwr("R8", 8'h0C, 32'h11111111);
        step("R8", 1'b1, 8'h0C, 32'h22222222, 1'b1, 8'hC0, 32'h00000008);
        rd2("R8", 8'hC0, 8'h0C);
        rwr("R8", 8'hC0, 32'h00000008);
        rwr("R8", 8'h3C, 32'h33333333);
        step("R8", 1'b1, 8'hC4, 32'h00000080, 1'b1, 8'h3C, 32'h44444444);
        rd2("R8", 8'hC4, 8'hC4);
        hwr("R8", 8'hC4, 32'h00000080);

        // R9: scratch shared by both ports, ends of the range, collision
        hwr("R9", 8'h40, 32'hDEADBEEF);
        rwr("R9", 8'hAC, 32'hCAFEF00D);
        rd2("R9", 8'hAC, 8'h40);
        step("R9", 1'b1, 8'h60, 32'h11112222, 1'b1, 8'h60, 32'h33334444);
        rd2("R9", 8'h60, 8'h60);
        rd2("R9", 8'hC0, 8'hC4);

        // R10: unmapped offsets and writes a port may not make
        hwr("R10", 8'hB0, 32'hFFFFFFFF);
        rwr("R10", 8'hC8, 32'hFFFFFFFF);
        hwr("R10", 8'hFC, 32'hFFFFFFFF);
        rd2("R10", 8'hB0, 8'hFC);
        rd2("R10", 8'hD4, 8'hCC);
        hwr("R10", 8'h20, 32'h77777777);
        rd2("R10", 8'h20, 8'hC4);
        rwr("R10", 8'h10, 32'h66666666);
        rd2("R10", 8'h10, 8'hC0);
        hwr("R10", 8'h10, 32'h55555555);
        hwr("R10", 8'hC0, 32'h000000FF);
        rd2("R10", 8'hC0, 8'h10);
        rwr("R10", 8'hD0, 32'h000000FF);
        rwr("R10", 8'hC4, 32'h000000FF);
        rd2("R10", 8'hD0, 8'hC4);
        rwr("R10", 8'hC0, 32'h00000010);
        rd2("R10", 8'hC0, 8'hC0);

        finish_run();
    end
endmodule